// File: doc/BRIEF.md
# Delay-line bring-up sequencer

This block powers up a delay-locked loop that follows the card clock. When the card clock has just been reprogrammed to a frequency above a threshold (52 MHz by default), a start pulse launches a three-step rewrite of a 32-bit delay-line configuration word. The block pauses for a fixed number of microsecond ticks after each step. It then watches the loop's lock indication at a fixed interval until the lock appears or a time budget runs out.

The configuration word is owned by this block and comes out of reset with a parameter value. Each step touches only its own bits:
- The quiet step clears the loop enable (bit 21) and the five compensation enables (bit 18 and bits 27:24).
- The prepare step sets the compensation enables, the search-mode bit (bit 16), the initial count 0xC00 (bits 11:10) and the internal phase value 3 (bits 1:0).
- The arm step sets the loop enable.

A one-cycle done pulse ends every run. A lock-fail flag reports a run that timed out. All waits are counted in ticks of an external one-microsecond strobe, and the three durations are parameters so that a bench can shorten them.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset, cfg_o equals CFG_RESET, and busy_o, done_o and lock_fail_o are 0.
- R2: A run is accepted only in a cycle where busy_o is 0 and start_i, clk_changed_i and freq_i > FREQ_MIN_HZ are all true; busy_o is 1 from the next cycle. A start with freq_i equal to the threshold, or without clk_changed_i, leaves cfg_o and busy_o unchanged.
- R3: At the acceptance edge, cfg_o bits 21, 18 and 27:24 become 0 and every other bit keeps its value.
- R4: After WAIT_US ticks of tick_i counted from acceptance, cfg_o is ORed with 0x0F05_0C03 (bits 27:24, 18, 16, 11:10, 1:0), with no other change.
- R5: After a further WAIT_US ticks, cfg_o bit 21 is set; after a third WAIT_US ticks, polling starts, and bit 21 stays set while polling.
- R6: lock_i is sampled in the first polling cycle, and again each time POLL_US further ticks have been counted.
- R7: A sample with lock_i high ends the run: done_o is 1 for exactly one cycle, busy_o is 0 in that cycle, and lock_fail_o is 0.
- R8: A sample with lock_i low, taken once at least TIMEOUT_US ticks have passed since polling began, ends the run with a one-cycle done_o and lock_fail_o set. cfg_o is left as it is. lock_fail_o holds until the next accepted run clears it.
- R9: A start pulse that arrives while busy_o is 1 has no effect on cfg_o, on the step timing or on the end of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse to bring up the loop |
| clk_changed_i | input | 1 | Card clock was just reprogrammed |
| freq_i | input | FREQ_W | New card clock frequency in Hz |
| tick_us_i | input | 1 | One-cycle strobe once per microsecond |
| lock_i | input | 1 | Lock indication from the delay loop |
| cfg_o | output | 32 | Delay-line configuration word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| lock_fail_o | output | 1 | Last run ended without lock |

## Verification
The bench uses a reset value with bits set both inside and outside the step masks. A design that used plain writes in place of read-modify-write would lose the untouched bits, and the second run would show it. It offers start at exactly 52 MHz and without the clock-changed flag, so a comparison of the wrong sense or a missing term would start a run where none is due. It raises lock between two samples, and a design that watches lock continuously would then end the run early. One run never locks: it checks that the run gives up only at the sample taken once the budget has expired, that the fail flag stays set, and that a later locked run clears it. Extra start pulses are sent in the middle of a run, and a design that restarts on them would stretch the step timing.

// File: rtl/dlbs_pkg.sv
package dlbs_pkg;

    localparam int CFG_W       = 32;
    localparam int BIT_ENABLE  = 21;
    localparam int BIT_SEARCH  = 16;
    localparam int BIT_COMP_LO = 18;
    localparam int COMP_HI_LSB = 24;

    localparam logic [CFG_W-1:0] ENABLE_MASK = CFG_W'(1) << BIT_ENABLE;
    localparam logic [CFG_W-1:0] COMP_MASK   = (CFG_W'(1) << BIT_COMP_LO) |
                                               (CFG_W'(4'hF) << COMP_HI_LSB);
    localparam logic [CFG_W-1:0] SEARCH_MASK = CFG_W'(1) << BIT_SEARCH;
    localparam logic [CFG_W-1:0] INIT_COUNT  = CFG_W'(32'h0000_0C00);
    localparam logic [CFG_W-1:0] PHASE_SEL   = CFG_W'(32'h0000_0003);

    localparam logic [CFG_W-1:0] QUIET_CLEAR = ENABLE_MASK | COMP_MASK;
    localparam logic [CFG_W-1:0] PREP_SET    = COMP_MASK | SEARCH_MASK | INIT_COUNT | PHASE_SEL;
    localparam logic [CFG_W-1:0] ARM_SET     = ENABLE_MASK;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUIET,
        ST_PREP,
        ST_ARM,
        ST_POLL
    } dlbs_state_e;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_QUIET,
        STEP_PREP,
        STEP_ARM
    } dlbs_step_e;

    typedef struct packed {
        dlbs_state_e      st;
        logic [CFG_W-1:0] cfg;
        logic             chk;
        logic             done;
        logic             fail;
    } dlbs_regs_t;

endpackage

// File: rtl/dlbs_tick_counter.sv
module dlbs_tick_counter #(
    parameter int W        = 8,
    parameter bit SATURATE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);

    logic [W-1:0] cnt_d, cnt_q;

    generate
        if (SATURATE) begin : g_sat
            // holds at the limit; hit is a level once the limit is reached
            always_comb begin
                cnt_d = cnt_q;
                if (clr_i)
                    cnt_d = '0;
                else if (tick_i && (cnt_q != limit_i))
                    cnt_d = cnt_q + W'(1);
            end
            assign hit_o = (cnt_q == limit_i);
        end else begin : g_wrap
            // returns to zero on the tick that completes a period
            always_comb begin
                cnt_d = cnt_q;
                if (clr_i)
                    cnt_d = '0;
                else if (tick_i)
                    cnt_d = (cnt_q == limit_i - W'(1)) ? '0 : cnt_q + W'(1);
            end
            assign hit_o = tick_i && !clr_i && (cnt_q == limit_i - W'(1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/dlbs_step_mask.sv
module dlbs_step_mask
    import dlbs_pkg::*;
(
    input  dlbs_step_e       step_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [CFG_W-1:0] cfg_o
);

    always_comb begin
        unique case (step_i)
            STEP_QUIET: cfg_o = cfg_i & ~QUIET_CLEAR;
            STEP_PREP:  cfg_o = cfg_i | PREP_SET;
            STEP_ARM:   cfg_o = cfg_i | ARM_SET;
            default:    cfg_o = cfg_i;
        endcase
    end

endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
    import dlbs_pkg::*;
#(
    parameter int                WAIT_US     = 1000,
    parameter int                POLL_US     = 2000,
    parameter int                TIMEOUT_US  = 1000000,
    parameter int                FREQ_W      = 32,
    parameter int                FREQ_MIN_HZ = 52000000,
    parameter logic [CFG_W-1:0]  CFG_RESET   = 32'h8F24_4100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clk_changed_i,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic              tick_us_i,
    input  logic              lock_i,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              lock_fail_o
);

    localparam int GAP_MAX = (WAIT_US > POLL_US) ? WAIT_US : POLL_US;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int ELAP_W  = $clog2(TIMEOUT_US + 1);

    dlbs_regs_t       r_d, r_q;
    dlbs_step_e       step;
    logic [CFG_W-1:0] cfg_next;
    logic             freq_hi, go, gap_hit, elapsed_full;
    logic [GAP_W-1:0] gap_limit;

    assign freq_hi   = freq_i > FREQ_W'(FREQ_MIN_HZ);
    assign go        = (r_q.st == ST_IDLE) && start_i && clk_changed_i && freq_hi;
    assign gap_limit = (r_q.st == ST_POLL) ? GAP_W'(POLL_US) : GAP_W'(WAIT_US);

    // step gaps and poll interval share one wrapping counter
    dlbs_tick_counter #(.W(GAP_W), .SATURATE(1'b0)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (r_q.st == ST_IDLE),
        .tick_i  (tick_us_i),
        .limit_i (gap_limit),
        .hit_o   (gap_hit)
    );

    // time spent polling, held once the budget is used up
    dlbs_tick_counter #(.W(ELAP_W), .SATURATE(1'b1)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (r_q.st != ST_POLL),
        .tick_i  (tick_us_i),
        .limit_i (ELAP_W'(TIMEOUT_US)),
        .hit_o   (elapsed_full)
    );

    always_comb begin
        unique case (r_q.st)
            ST_IDLE:  step = go      ? STEP_QUIET : STEP_NONE;
            ST_QUIET: step = gap_hit ? STEP_PREP  : STEP_NONE;
            ST_PREP:  step = gap_hit ? STEP_ARM   : STEP_NONE;
            default:  step = STEP_NONE;
        endcase
    end

    dlbs_step_mask u_mask (
        .step_i (step),
        .cfg_i  (r_q.cfg),
        .cfg_o  (cfg_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cfg  = cfg_next;
        r_d.done = 1'b0;
        r_d.chk  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    r_d.st   = ST_QUIET;
                    r_d.fail = 1'b0;
                end
            end
            ST_QUIET: if (gap_hit) r_d.st = ST_PREP;
            ST_PREP:  if (gap_hit) r_d.st = ST_ARM;
            ST_ARM: begin
                if (gap_hit) begin
                    r_d.st  = ST_POLL;
                    r_d.chk = 1'b1;
                end
            end
            ST_POLL: begin
                if (r_q.chk && lock_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (r_q.chk && elapsed_full) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.fail = 1'b1;
                end else begin
                    r_d.chk = gap_hit;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '{st: ST_IDLE, cfg: CFG_RESET, chk: 1'b0, done: 1'b0, fail: 1'b0};
        else
            r_q <= r_d;
    end

    assign cfg_o       = r_q.cfg;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign lock_fail_o = r_q.fail;

    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && clk_changed_i && freq_hi) |=> busy_o);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && r_q.st != ST_POLL) |=> busy_o);

    a_r3_cfg_moves_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> busy_o);

    a_r5_enable_while_polling: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_POLL) |-> cfg_o[BIT_ENABLE]);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_fail_o) |-> (done_o || $rose(busy_o)));

endmodule

// File: tb/sim_dll_bringup_seq.sv
module sim_dll_bringup_seq;

    localparam int          WAIT_US  = 3;
    localparam int          POLL_US  = 4;
    localparam int          TIMEOUT  = 12;
    localparam int          FMIN     = 52000000;
    localparam logic [31:0] RST_CFG  = 32'h8F24_4100;
    localparam logic [31:0] CLR_M    = 32'h0F24_0000;
    localparam logic [31:0] SET2_M   = 32'h0F05_0C03;
    localparam logic [31:0] SET3_M   = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, chg = 1'b0, tick = 1'b0, lock = 1'b0;
    logic [31:0] freq = 32'd0;
    logic [31:0] cfg;
    logic        busy, done, fail;
    logic        tick_en = 1'b0;

    int checks = 0, fails = 0, cyc = 0;

    // reference model state
    int          m_phase = 0, m_cnt = 0, m_elap = 0;
    bit          m_chk = 0, m_done = 0, m_fail = 0;
    logic [31:0] m_cfg = RST_CFG;

    always #2 clk = ~clk;

    dll_bringup_seq #(.WAIT_US(WAIT_US), .POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT),
                      .FREQ_MIN_HZ(FMIN), .CFG_RESET(RST_CFG)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .clk_changed_i(chg), .freq_i(freq),
        .tick_us_i(tick), .lock_i(lock), .cfg_o(cfg), .busy_o(busy), .done_o(done),
        .lock_fail_o(fail));

    always @(posedge clk) begin
        bit nchk;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_elap = 0; m_chk = 0; m_done = 0; m_fail = 0;
            m_cfg = RST_CFG;
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (start && chg && freq > FMIN) begin
                        m_cfg = m_cfg & ~CLR_M; m_phase = 1; m_cnt = 0; m_fail = 0;
                   end
                1, 2, 3: if (tick) begin
                        if (m_cnt == WAIT_US - 1) begin
                            m_cnt = 0;
                            if (m_phase == 1) m_cfg = m_cfg | SET2_M;
                            if (m_phase == 2) m_cfg = m_cfg | SET3_M;
                            if (m_phase == 3) begin m_elap = 0; m_chk = 1; end
                            m_phase = m_phase + 1;
                        end else m_cnt++;
                   end
                default: begin
                    if (m_chk && lock) begin
                        m_phase = 0; m_done = 1;
                    end else if (m_chk && m_elap >= TIMEOUT) begin
                        m_phase = 0; m_done = 1; m_fail = 1;
                    end else begin
                        nchk = 0;
                        if (tick) begin
                            if (m_elap < TIMEOUT) m_elap++;
                            if (m_cnt == POLL_US - 1) begin m_cnt = 0; nchk = 1; end
                            else m_cnt++;
                        end
                        m_chk = nchk;
                    end
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            check(cfg == m_cfg, "R4 cfg", cfg, m_cfg);
            check(busy == (m_phase != 0), "R9 busy", 32'(busy), 32'(m_phase != 0));
            check(done == m_done, "R6 done", 32'(done), 32'(m_done));
            check(fail == m_fail, "R8 fail", 32'(fail), 32'(m_fail));
        end
    end

    // microsecond strobe every third cycle
    initial forever begin
        @(negedge clk);
        tick = tick_en && (cyc % 3 == 0);
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: actual 0x%08h expected 0x%08h", cyc, 20000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    task automatic pulse_start(input logic [31:0] f, input logic c);
        @(negedge clk);
        freq = f; chg = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0; chg = 1'b0;
    endtask

    task automatic wait_phase(input int p);
        for (int i = 0; i < 2000 && m_phase != p; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cfg == RST_CFG, "R1 cfg", cfg, RST_CFG);
        check(!busy && !done && !fail, "R1 flags", {busy, done, fail}, 0);
        tick_en = 1'b1;

        // R2: qualification of the start pulse
        pulse_start(FMIN, 1'b1);
        repeat (2) @(negedge clk);
        check(!busy && cfg == RST_CFG, "R2 at threshold", cfg, RST_CFG);
        pulse_start(100000000, 1'b0);
        repeat (2) @(negedge clk);
        check(!busy && cfg == RST_CFG, "R2 no change flag", cfg, RST_CFG);
        @(negedge clk); chg = 1'b1; freq = 100000000;
        @(negedge clk); chg = 1'b0;
        check(!busy, "R2 no start", 32'(busy), 0);

        // run 1: lock appears part way through polling
        lock = 1'b0;
        @(negedge clk); freq = 100000000; chg = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0; chg = 1'b0;
        check(busy == 1'b1, "R2 accepted", 32'(busy), 1);
        check(cfg == 32'h8000_4100, "R3 quiet step", cfg, 32'h8000_4100);
        repeat (2) @(negedge clk);
        start = 1'b1; chg = 1'b1;   // R9: ignored while busy
        @(negedge clk); start = 1'b0; chg = 1'b0;
        wait_phase(2);
        check(cfg == 32'h8F05_4D03, "R4 prepare step", cfg, 32'h8F05_4D03);
        start = 1'b1; chg = 1'b1;
        @(negedge clk); start = 1'b0; chg = 1'b0;
        wait_phase(4);
        check(cfg == 32'h8F25_4D03, "R5 arm step", cfg, 32'h8F25_4D03);
        repeat (5) @(negedge clk);
        lock = 1'b1;
        wait_phase(0);
        @(negedge clk);
        check(fail == 1'b0, "R7 locked run", 32'(fail), 0);
        check(cfg == 32'h8F25_4D03, "R5 final word", cfg, 32'h8F25_4D03);

        // run 2: never locks
        lock = 1'b0;
        pulse_start(200000000, 1'b1);
        check(cfg == 32'h8001_4D03, "R3 second quiet", cfg, 32'h8001_4D03);
        wait_phase(0);
        @(negedge clk);
        check(fail == 1'b1, "R8 timeout flag", 32'(fail), 1);
        check(cfg == 32'h8F25_4D03, "R8 word kept", cfg, 32'h8F25_4D03);
        repeat (6) @(negedge clk);
        check(fail == 1'b1, "R8 flag held", 32'(fail), 1);

        // run 3: already locked at first sample
        lock = 1'b1;
        pulse_start(60000000, 1'b1);
        wait_phase(0);
        @(negedge clk);
        check(fail == 1'b0, "R7 fail cleared", 32'(fail), 0);
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule